// File: doc/BRIEF.md
# Adapter Reset and Init Sequencer

This block takes a network adapter's glue logic out of reset in a fixed order. It keeps its own copy of a byte-wide reset register, in which each of three set bits lets one unit run: the chip core, the host-interface unit and the FIFO. It also programs an interrupt-control register and a FIFO-threshold register. Every register write leaves the block as a one-cycle strobe that carries an address and a data byte. Whatever register bus sits behind the block turns those strobes into real writes.

Three one-cycle requests start the work. An open request runs the full bring-up. The chip core is released first. All three units are then put into reset together and held there for a programmable number of clock cycles. After the hold, the units are released one write at a time. Last, the interrupt and threshold registers are programmed. A close request writes zero to the reset register. An enable request only releases the chip core and then waits out the hold. While a sequence runs the block reports busy. When it finishes it raises done, which stays high until the next accepted request.

Top module: `adapter_reset_seq`

## Requirements
- R1: After reset, busy, done and wr_stb are all low and the stored reset image is zero.
- R2: An open request first writes address 0 (reset register) with bit 0 (core run) set and every other bit kept from the stored image. It then writes address 0 with bit 0, bit 1 (host-interface run) and bit 2 (FIFO run) cleared and every other bit kept.
- R3: After the all-reset write, exactly HOLD_CYCLES clock cycles pass with no strobe before the next write.
- R4: The releases are three consecutive writes to address 0. They set bit 0, then bit 1, then bit 2, and each one keeps the bits already set (0x01, 0x03, 0x07 from a zero image).
- R5: The write after the releases goes to address 1 (interrupt control) with data 0x03: bit 0 is the system interrupt enable and bit 1 is the bus-error enable.
- R6: The last write of the open sequence goes to address 2 (FIFO threshold) with data 30 (0x1E).
- R7: A close request gives exactly one write, address 0 with data 0x00.
- R8: An enable request writes address 0 with bit 0 set and the other bits kept. It then makes no write for HOLD_CYCLES cycles and finishes.
- R9: busy is high from the cycle after an accepted request through the cycle of the last write or hold cycle, and low after that. done goes high in the cycle after completion and stays high until the next accepted request.
- R10: A request that arrives while busy is high has no effect: it changes neither the write list nor the timing.
- R11: When an idle block sees several requests in the same cycle, close wins over open, and open wins over enable.
- R12: Each strobe lasts one cycle, and the writes of a sequence fall in consecutive cycles except for the hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| open_req | input | 1 | Start the full bring-up sequence |
| close_req | input | 1 | Put all units into reset |
| enable_req | input | 1 | Release the chip core only, then hold |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_addr | output | ADDR_W | Register address of the write |
| wr_data | output | DATA_W | Data of the write |
| busy | output | 1 | A sequence is running |
| done | output | 1 | The last sequence has finished |

## Verification
The hardest case to reach is a bring-up that starts from a stored image that is not zero. That is the only case that shows whether the first write really keeps the bits already set and whether the all-reset write clears only the three run bits. The bench runs one open sequence to completion and then starts a second one straight away, so the second starts from an image of 0x07. During a hold window the bench also pulses the close and enable requests and checks that they are ignored. A follow-on enable is issued after a close, so the image it keeps is known.

// File: rtl/adapter_seq_pkg.sv
package adapter_seq_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CORE_PRE,
      ST_ALL_LOW,
      ST_HOLD,
      ST_REL_CORE,
      ST_REL_HOST,
      ST_REL_FIFO,
      ST_IRQ_CFG,
      ST_THRESH,
      ST_CLOSE,
      ST_EN_CORE,
      ST_EN_HOLD
   } seq_state_e;
endpackage

// File: rtl/seq_hold_timer.sv
module seq_hold_timer #(
   parameter int HOLD_CYCLES = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic running,
   output logic last
);
   localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
   localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(HOLD_CYCLES);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load)         cnt_q <= LOAD_VAL;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign running = (cnt_q != '0);
   assign last    = (cnt_q == CNT_W'(1));

   a_r3_no_reload_while_running: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> !load);
endmodule

// File: rtl/seq_write_decoder.sv
module seq_write_decoder
   import adapter_seq_pkg::*;
#(
   parameter int ADDR_W        = 4,
   parameter int DATA_W        = 8,
   parameter int ADDR_RESET    = 0,
   parameter int ADDR_IRQ      = 1,
   parameter int ADDR_FIFO_THR = 2,
   parameter int THRESHOLD     = 30,
   parameter int CORE_BIT      = 0,
   parameter int HOST_BIT      = 1,
   parameter int FIFO_BIT      = 2,
   parameter int IRQ_SYS_BIT   = 0,
   parameter int IRQ_ERR_BIT   = 1
) (
   input  seq_state_e        state,
   input  logic [DATA_W-1:0] image,
   output logic              stb,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] data
);
   localparam logic [DATA_W-1:0] CORE_M = DATA_W'(1) << CORE_BIT;
   localparam logic [DATA_W-1:0] HOST_M = DATA_W'(1) << HOST_BIT;
   localparam logic [DATA_W-1:0] FIFO_M = DATA_W'(1) << FIFO_BIT;
   localparam logic [DATA_W-1:0] RUN_M  = CORE_M | HOST_M | FIFO_M;
   localparam logic [DATA_W-1:0] IRQ_M  = (DATA_W'(1) << IRQ_SYS_BIT) | (DATA_W'(1) << IRQ_ERR_BIT);

   always_comb begin
      stb  = 1'b1;
      addr = ADDR_W'(ADDR_RESET);
      data = image;
      case (state)
         ST_CORE_PRE, ST_EN_CORE, ST_REL_CORE: data = image | CORE_M;
         ST_ALL_LOW:  data = image & ~RUN_M;
         ST_REL_HOST: data = image | HOST_M;
         ST_REL_FIFO: data = image | FIFO_M;
         ST_IRQ_CFG: begin
            addr = ADDR_W'(ADDR_IRQ);
            data = IRQ_M;
         end
         ST_THRESH: begin
            addr = ADDR_W'(ADDR_FIFO_THR);
            data = DATA_W'(THRESHOLD);
         end
         ST_CLOSE:   data = '0;
         default:    stb  = 1'b0;
      endcase
   end
endmodule

// File: rtl/adapter_reset_seq.sv
module adapter_reset_seq
   import adapter_seq_pkg::*;
#(
   parameter int HOLD_CYCLES   = 100,
   parameter int ADDR_W        = 4,
   parameter int DATA_W        = 8,
   parameter int ADDR_RESET    = 0,
   parameter int ADDR_IRQ      = 1,
   parameter int ADDR_FIFO_THR = 2,
   parameter int THRESHOLD     = 30,
   parameter int CORE_BIT      = 0,
   parameter int HOST_BIT      = 1,
   parameter int FIFO_BIT      = 2,
   parameter int IRQ_SYS_BIT   = 0,
   parameter int IRQ_ERR_BIT   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              open_req,
   input  logic              close_req,
   input  logic              enable_req,
   output logic              wr_stb,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              busy,
   output logic              done
);
   if (HOLD_CYCLES < 1) begin : g_bad_hold
      $error("HOLD_CYCLES must be at least 1");
   end
   if (CORE_BIT >= DATA_W || HOST_BIT >= DATA_W || FIFO_BIT >= DATA_W) begin : g_bad_bits
      $error("run bit positions must lie inside DATA_W");
   end
   if (THRESHOLD >= (1 << DATA_W)) begin : g_bad_thr
      $error("THRESHOLD does not fit DATA_W");
   end
   if (ADDR_RESET >= (1 << ADDR_W) || ADDR_IRQ >= (1 << ADDR_W) || ADDR_FIFO_THR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("register address does not fit ADDR_W");
   end

   seq_state_e        state_q, state_d;
   logic [DATA_W-1:0] image_q;
   logic              tmr_load, tmr_running, tmr_last;
   logic              finish;

   seq_write_decoder #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADDR_RESET(ADDR_RESET), .ADDR_IRQ(ADDR_IRQ),
      .ADDR_FIFO_THR(ADDR_FIFO_THR), .THRESHOLD(THRESHOLD), .CORE_BIT(CORE_BIT),
      .HOST_BIT(HOST_BIT), .FIFO_BIT(FIFO_BIT), .IRQ_SYS_BIT(IRQ_SYS_BIT),
      .IRQ_ERR_BIT(IRQ_ERR_BIT)
   ) u_dec (
      .state(state_q), .image(image_q), .stb(wr_stb), .addr(wr_addr), .data(wr_data)
   );

   seq_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .running(tmr_running), .last(tmr_last)
   );

   assign tmr_load = (state_q == ST_ALL_LOW) || (state_q == ST_EN_CORE);
   assign busy     = (state_q != ST_IDLE);

   always_comb begin
      state_d = state_q;
      finish  = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (close_req)       state_d = ST_CLOSE;
            else if (open_req)   state_d = ST_CORE_PRE;
            else if (enable_req) state_d = ST_EN_CORE;
         end
         ST_CORE_PRE: state_d = ST_ALL_LOW;
         ST_ALL_LOW:  state_d = ST_HOLD;
         ST_HOLD:     if (tmr_last) state_d = ST_REL_CORE;
         ST_REL_CORE: state_d = ST_REL_HOST;
         ST_REL_HOST: state_d = ST_REL_FIFO;
         ST_REL_FIFO: state_d = ST_IRQ_CFG;
         ST_IRQ_CFG:  state_d = ST_THRESH;
         ST_THRESH: begin
            state_d = ST_IDLE;
            finish  = 1'b1;
         end
         ST_CLOSE: begin
            state_d = ST_IDLE;
            finish  = 1'b1;
         end
         ST_EN_CORE:  state_d = ST_EN_HOLD;
         ST_EN_HOLD: begin
            if (tmr_last) begin
               state_d = ST_IDLE;
               finish  = 1'b1;
            end
         end
         default:     state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         image_q <= '0;
         done    <= 1'b0;
      end else begin
         state_q <= state_d;
         if (wr_stb && wr_addr == ADDR_W'(ADDR_RESET)) image_q <= wr_data;
         if (finish)                                 done <= 1'b1;
         else if (!busy && state_d != ST_IDLE)       done <= 1'b0;
      end
   end

   a_r9_stb_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> busy);
   a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   a_r3_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_running |-> !wr_stb);
   a_r4_release_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && (state_q == ST_REL_CORE || state_q == ST_REL_HOST || state_q == ST_REL_FIFO))
         |-> ((wr_data & image_q) == image_q));
   a_r7_close_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && state_q == ST_CLOSE) |-> (wr_data == '0 && wr_addr == ADDR_W'(ADDR_RESET)));
   a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !finish) |=> busy);
endmodule

// File: tb/adapter_reset_seq_bench.sv
module adapter_reset_seq_bench;
   localparam int D = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       open_req = 1'b0, close_req = 1'b0, enable_req = 1'b0;
   logic       wr_stb, busy, done;
   logic [3:0] wr_addr;
   logic [7:0] wr_data;

   int checks = 0, errors = 0, cyc = 0, n = 0;
   logic [3:0] ra [0:31];
   logic [7:0] rd [0:31];
   int         rc [0:31];

   always #4 clk = ~clk;

   adapter_reset_seq #(.HOLD_CYCLES(D)) u_adapter_reset_seq (
      .clk(clk), .rst_n(rst_n), .open_req(open_req), .close_req(close_req),
      .enable_req(enable_req), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
      .busy(busy), .done(done)
   );

   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (wr_stb && n < 32) begin
         ra[n] <= wr_addr;
         rd[n] <= wr_data;
         rc[n] <= cyc;
         n     <= n + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic expw(input int i, input int a, input int d, input string req);
      chk(ra[i] == 4'(a), req, $sformatf("write %0d addr", i), ra[i], a);
      chk(rd[i] == 8'(d), req, $sformatf("write %0d data", i), rd[i], d);
   endtask

   task automatic pulse(input bit o, input bit c, input bit e);
      @(negedge clk);
      open_req = o; close_req = c; enable_req = e;
      @(negedge clk);
      open_req = 0; close_req = 0; enable_req = 0;
   endtask

   task automatic wait_done(output int at);
      at = -1;
      for (int k = 0; k < 200; k++) begin
         if (done) begin at = cyc; break; end
         @(negedge clk);
      end
      chk(at >= 0, "R9", "done seen", at, 0);
      @(negedge clk);
   endtask

   task automatic t_reset;
      chk(!busy && !done && !wr_stb, "R1", "outputs idle after reset", {busy, done, wr_stb}, 0);
   endtask

   task automatic t_open(input int img, input bit poke);
      int at;
      n = 0;
      pulse(1, 0, 0);
      chk(busy, "R9", "busy after accept", busy, 1);
      if (poke) begin
         repeat (2) @(negedge clk);
         pulse(0, 1, 0);
         pulse(0, 0, 1);
         pulse(1, 0, 0);
      end
      wait_done(at);
      chk(n == 7, poke ? "R10" : "R2", "write count", n, 7);
      expw(0, 0, img | 8'h01, "R2");
      expw(1, 0, img & 8'hF8, "R2");
      chk(rc[2] - rc[1] == D + 1, "R3", "hold gap", rc[2] - rc[1], D + 1);
      expw(2, 0, (img & 8'hF8) | 8'h01, "R4");
      expw(3, 0, (img & 8'hF8) | 8'h03, "R4");
      expw(4, 0, (img & 8'hF8) | 8'h07, "R4");
      expw(5, 1, 8'h03, "R5");
      expw(6, 2, 30, "R6");
      chk(rc[6] - rc[2] == 4 && rc[1] - rc[0] == 1, "R12", "consecutive writes", rc[6] - rc[2], 4);
      chk(at == rc[6] + 1, "R9", "done one cycle after last write", at, rc[6] + 1);
      chk(!busy && done, "R9", "idle and done held", {busy, done}, 1);
   endtask

   task automatic t_close(input bit all);
      int at;
      n = 0;
      if (all) pulse(1, 1, 1); else pulse(0, 1, 0);
      chk(!done, "R9", "done cleared on accept", done, 0);
      wait_done(at);
      repeat (D + 2) @(negedge clk);
      chk(n == 1, all ? "R11" : "R7", "close write count", n, 1);
      expw(0, 0, 0, all ? "R11" : "R7");
   endtask

   task automatic t_enable(input int img);
      int at;
      n = 0;
      pulse(0, 0, 1);
      wait_done(at);
      chk(n == 1, "R8", "enable write count", n, 1);
      expw(0, 0, img | 1, "R8");
      chk(at - rc[0] == D + 1, "R8", "enable hold length", at - rc[0], D + 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_open(8'h00, 0);
      t_open(8'h07, 0);
      t_enable(8'h07);
      t_close(0);
      t_enable(8'h00);
      t_close(1);
      t_open(8'h00, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule